// File: doc/BRIEF.md
# Power-Good Start-Up Sequencer and PLL Mode Selector

This block decides when a clock buffer may start driving its outputs and which PLL mode it runs in. It watches one power-good input. On the first rising edge of that input it captures the board straps: the three-level PLL mode pin and two three-level address pins. Each three-level pin arrives already decoded into a 2-bit level. After that first edge, the input only moves the device into power-down (low) and back out of it (high). The straps are never captured again.

Outputs stay gated until a stabilization count of reference-clock cycles has elapsed. The first start uses a long count and every later power-down exit uses a shorter one. The effective PLL mode normally follows the captured strap. A software override can replace it with a code held in a register, while the read-back field keeps showing the captured strap.

Top module: `pwrgd_mode_ctl`

## Requirements
- R1: After reset, `out_run_o`, `started_o` and `pd_o` are 0, `addr_o` is 0, and `mode_rb_o` is 01 (bypass, the level an unconnected biased pin gives). With the override clear, `mode_o` is also 01. `out_run_o` stays 0 while `pwrgd_i` is low.
- R2: The first clock edge that sees `pwrgd_i` high after it was low sets `started_o`. The same edge captures `mode_pin_i` into `mode_rb_o` and `{strap1_i, strap0_i}` into `addr_o`. Mode codes are 00 = PLL low bandwidth, 01 = PLL bypassed, 11 = PLL high bandwidth, and a pin code of 10 is captured as 01.
- R3: Once `started_o` is 1, later changes on the strap pins and later rising edges of `pwrgd_i` leave `mode_rb_o` and `addr_o` unchanged.
- R4: On the first clock edge that sees `pwrgd_i` low after start-up, `out_run_o` falls and `pd_o` rises. `pd_o` falls on the first edge that sees `pwrgd_i` high again.
- R5: On the first start, `out_run_o` rises exactly `STAB_CYCLES` clock edges after the edge that captured the straps, and not before.
- R6: On a power-down exit, `out_run_o` rises exactly `PDX_CYCLES` clock edges after the edge that saw `pwrgd_i` high again. If `pwrgd_i` falls during the count, the count restarts from zero on the next rise.
- R7: With `sw_override_i` = 0, `mode_o` equals `mode_rb_o`.
- R8: With `sw_override_i` = 1, `mode_o` takes its value from `sw_mode_i`, and `mode_rb_o` keeps the captured strap.
- R9: A `sw_mode_i` code of 10 under override gives `mode_o` = 01 (bypass).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low cold reset |
| pwrgd_i | input | 1 | Power-good: high runs, low requests power-down |
| mode_pin_i | input | 2 | Decoded level of the three-level PLL mode strap |
| strap0_i | input | 2 | Decoded level of address strap 0 |
| strap1_i | input | 2 | Decoded level of address strap 1 |
| sw_override_i | input | 1 | Software override enable for the PLL mode |
| sw_mode_i | input | 2 | Software PLL mode code |
| mode_rb_o | output | 2 | Captured strap mode, for read-back |
| mode_o | output | 2 | Effective PLL mode |
| addr_o | output | 4 | Captured address straps {strap1, strap0} |
| started_o | output | 1 | Straps have been captured |
| pd_o | output | 1 | Device is in power-down after start-up |
| out_run_o | output | 1 | Outputs may run |

## Verification
The bench builds the block with `STAB_CYCLES` = 12 and `PDX_CYCLES` = 5 in place of the millisecond-scale defaults. With these values both stabilization windows can be checked at their exact edge: one cycle before the output rises and the cycle in which it rises. They also leave room for several power-down and exit rounds, a second cold reset that captures a 10 strap code, and a power-down during the exit count within a short run.

// File: rtl/pwrgd_mode_ctl.sv
module pwrgd_mode_ctl #(
  parameter int unsigned STAB_CYCLES = 140000,
  parameter int unsigned PDX_CYCLES  = 20000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwrgd_i,
  input  logic [1:0] mode_pin_i,
  input  logic [1:0] strap0_i,
  input  logic [1:0] strap1_i,
  input  logic       sw_override_i,
  input  logic [1:0] sw_mode_i,
  output logic [1:0] mode_rb_o,
  output logic [1:0] mode_o,
  output logic [3:0] addr_o,
  output logic       started_o,
  output logic       pd_o,
  output logic       out_run_o
);
  localparam int unsigned MAXC = (STAB_CYCLES > PDX_CYCLES) ? STAB_CYCLES : PDX_CYCLES;
  localparam int unsigned CW   = $clog2(MAXC + 1);

  logic          pg_q, cold_q, run_q, started_q;
  logic [CW-1:0] cnt_q, last_cnt;
  logic [1:0]    mode_q, mode_src;
  logic [3:0]    addr_q;
  logic          rise;

  assign rise     = pwrgd_i & ~pg_q;
  assign last_cnt = cold_q ? CW'(STAB_CYCLES - 1) : CW'(PDX_CYCLES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_q      <= 1'b0;
      cold_q    <= 1'b0;
      run_q     <= 1'b0;
      started_q <= 1'b0;
      cnt_q     <= '0;
      mode_q    <= 2'b01;
      addr_q    <= '0;
    end else begin
      pg_q <= pwrgd_i;
      if (!pwrgd_i) begin
        run_q <= 1'b0;
        cnt_q <= '0;
      end else if (rise) begin
        cnt_q  <= '0;
        cold_q <= ~started_q;
        if (!started_q) begin
          started_q <= 1'b1;
          mode_q    <= (mode_pin_i == 2'b10) ? 2'b01 : mode_pin_i;
          addr_q    <= {strap1_i, strap0_i};
        end
      end else if (!run_q) begin
        if (cnt_q == last_cnt) run_q <= 1'b1;
        else                   cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign mode_src  = sw_override_i ? sw_mode_i : mode_q;
  assign mode_o    = (mode_src == 2'b10) ? 2'b01 : mode_src;
  assign mode_rb_o = mode_q;
  assign addr_o    = addr_q;
  assign started_o = started_q;
  assign pd_o      = started_q & ~pg_q;
  assign out_run_o = run_q;
endmodule

// File: rtl/pwrgd_mode_ctl_chk.sv
module pwrgd_mode_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwrgd_i,
  input logic       sw_override_i,
  input logic [1:0] mode_rb_o,
  input logic [1:0] mode_o,
  input logic [3:0] addr_o,
  input logic       started_o,
  input logic       pd_o,
  input logic       out_run_o
);
  assert_run_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrgd_i |=> !out_run_o);

  assert_pd_on_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (started_o && !pwrgd_i) |=> pd_o);

  assert_straps_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    started_o |=> ($stable(mode_rb_o) && $stable(addr_o)));

  assert_start_on_pg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(started_o) |-> $past(pwrgd_i));

  assert_run_after_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_run_o) |-> (started_o && $past(pwrgd_i)));

  assert_hw_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_override_i |-> (mode_o == mode_rb_o));
endmodule

bind pwrgd_mode_ctl pwrgd_mode_ctl_chk u_chk (.*);

// File: tb/pwrgd_mode_ctl_bench.sv
module pwrgd_mode_ctl_bench;
  localparam int STAB = 12;
  localparam int PDX  = 5;

  logic clk = 1'b0, rst_n = 1'b0, pwrgd = 1'b0, ovr = 1'b0;
  logic [1:0] mpin = 2'b11, s0 = 2'b00, s1 = 2'b00, swm = 2'b00;
  logic [1:0] mode_rb, mode;
  logic [3:0] addr;
  logic started, pd, run;

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  typedef struct { string req; int sel; int exp; } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  pwrgd_mode_ctl #(.STAB_CYCLES(STAB), .PDX_CYCLES(PDX)) u_pwrgd_mode_ctl (
    .clk(clk), .rst_n(rst_n), .pwrgd_i(pwrgd), .mode_pin_i(mpin),
    .strap0_i(s0), .strap1_i(s1), .sw_override_i(ovr), .sw_mode_i(swm),
    .mode_rb_o(mode_rb), .mode_o(mode), .addr_o(addr),
    .started_o(started), .pd_o(pd), .out_run_o(run));

  function automatic int pick(int sel);
    case (sel)
      0: return int'(run);
      1: return int'(started);
      2: return int'(pd);
      3: return int'(mode_rb);
      4: return int'(mode);
      default: return int'(addr);
    endcase
  endfunction

  // monitor: compares queued expectations at each falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        int act;
        it  = q.pop_front();
        act = pick(it.sel);
        n_tests++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s sel=%0d actual=%0d expected=%0d", it.req, it.sel, act, it.exp);
        end
      end
    end
  end

  task automatic expect_val(string req, int sel, int exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    q.push_back(it);
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pwrgd = 1'b0; ovr = 1'b0;
    step(); step();
    rst_n = 1'b1;
  endtask

  task automatic wait_run(string req, int lim);
    for (int i = 1; i <= lim; i++) begin
      if (i == lim) expect_val(req, 0, 0);
      step();
    end
    expect_val(req, 0, 1);
    step();
  endtask

  initial begin
    int cyc = 0;
    while (!finished && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    mpin = 2'b11; s0 = 2'b00; s1 = 2'b00;
    do_reset();
    // R1 reset state
    expect_val("R1", 0, 0); expect_val("R1", 1, 0); expect_val("R1", 2, 0);
    expect_val("R1", 3, 1); expect_val("R1", 4, 1); expect_val("R1", 5, 0);
    step();
    for (int i = 0; i < 4; i++) step();
    expect_val("R1", 0, 0);
    step();

    // R2 first rising edge captures straps
    mpin = 2'b00; s0 = 2'b01; s1 = 2'b11;
    pwrgd = 1'b1;
    expect_val("R2", 1, 1); expect_val("R2", 3, 0); expect_val("R2", 5, 13);
    expect_val("R7", 4, 0); expect_val("R2", 0, 0);
    step();
    // R5: one edge already counted (the capture edge)
    wait_run("R5", STAB - 1);

    // R3 strap changes ignored after start
    mpin = 2'b11; s0 = 2'b00; s1 = 2'b10;
    expect_val("R3", 3, 0); expect_val("R3", 5, 13); expect_val("R7", 4, 0);
    step();

    // R8 / R9 software override
    ovr = 1'b1; swm = 2'b11;
    expect_val("R8", 4, 3); expect_val("R8", 3, 0);
    step();
    swm = 2'b10;
    expect_val("R9", 4, 1);
    step();
    swm = 2'b00;
    expect_val("R8", 4, 0);
    step();
    swm = 2'b11; ovr = 1'b0;
    expect_val("R7", 4, 0);
    step();

    // R4 power-down
    pwrgd = 1'b0;
    expect_val("R4", 2, 1); expect_val("R4", 0, 0);
    step();
    for (int i = 0; i < 3; i++) step();
    expect_val("R4", 0, 0); expect_val("R4", 2, 1);
    step();

    // R6 power-down exit, no recapture
    pwrgd = 1'b1;
    expect_val("R4", 2, 0); expect_val("R3", 3, 0); expect_val("R3", 5, 13);
    step();
    wait_run("R6", PDX - 1);

    // R6 power-down during exit count restarts it
    pwrgd = 1'b0; step(); step();
    pwrgd = 1'b1; step(); step();
    pwrgd = 1'b0;
    expect_val("R6", 0, 0);
    step();
    pwrgd = 1'b1;
    step();
    wait_run("R6", PDX - 1);

    // R2 second cold reset, pin code 10 captured as bypass
    do_reset();
    mpin = 2'b10; s0 = 2'b11; s1 = 2'b00;
    step();
    expect_val("R1", 1, 0); expect_val("R1", 0, 0);
    step();
    pwrgd = 1'b1;
    expect_val("R2", 3, 1); expect_val("R2", 5, 3); expect_val("R7", 4, 1);
    step();
    wait_run("R5", STAB - 1);

    step();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule